// File: doc/BRIEF.md
# SMBus Target Receive Acknowledge and Packet-Check Controller

This block is the receive-side decision logic of an I2C/SMBus target. Software programs a small control register. The bus front end supplies decoded events: start condition, stop condition, a byte-received strobe with the byte value, an own-address hit flag and arbitration loss. For each received byte the block registers an acknowledge or not-acknowledge decision. It marks the byte that carries the packet error check and compares that byte with a CRC-8 it keeps over the frame. It also drives the active-low alert line.

The acknowledge and packet-check controls can steer either the byte now being received or the one that follows, depending on a position bit. Hardware clears the packet-check request on bus events. The other control bits fall to zero whenever the block is disabled. Decisions appear one clock after the byte strobe, and the bus front end uses them to drive the acknowledge bit.

Top module: `smbrx_ackpec`

## Requirements
- R1: After `rst_n` is asserted, `ctl_q` reads 0, `alert_n` is 1, and `dec_vld`, `pec_err` and `pec_void` are 0. Control bit positions are: ACK=0, POS=1, PEC=2, ALERT=3, EN=4, SRST=5.
- R2: While SRST reads 1, every other control bit reads 0 and writes to them have no effect unless the same write clears SRST. No decisions are produced. Once SRST is written 0 with EN=1, bytes are decided again.
- R3: While EN reads 0, ALERT, PEC, POS and ACK read 0, and bytes produce no decision.
- R4: `alert_n` is 0 exactly while ALERT reads 1.
- R5: The first byte after a start is the address. With `own_hit` it is acknowledged. When `smb_mode` is 1 and `rx_data[7:1]` equals 7'b0001100, it is acknowledged only if ALERT is 1. Any other address gets a not-acknowledge, and the rest of the frame is not acknowledged.
- R6: With POS=0, a data byte is acknowledged per the ACK bit at the time it arrives, and it is the check byte if PEC is 1 at that time.
- R7: With POS=1, a data byte uses the ACK and PEC values captured at the previous byte strobe of the frame (address or data). Both values are zero right after a start.
- R8: The CRC-8 uses polynomial 0x07 and initial value 0x00. It covers the address byte and all non-check data bytes since the last start. A check byte that equals it is acknowledged per ACK. A check byte that differs gets a not-acknowledge and sets `pec_err`, which holds until the next start.
- R9: The PEC request bit is cleared by hardware on a start, on a stop, and when the check byte is decided.
- R10: Arbitration loss sets `pec_void` until the next start. While `pec_void` is set, any check byte counts as a mismatch.
- R11: A decision (`dec_vld`, `dec_ack`, `dec_pec`) is valid for one cycle, exactly one clock after the `ev_byte` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control register write value |
| ctl_q | output | 6 | Control register current value |
| smb_mode | input | 1 | Enables alert-response address matching |
| ev_start | input | 1 | Start or repeated start detected |
| ev_stop | input | 1 | Stop detected |
| ev_byte | input | 1 | A byte has been shifted in |
| rx_data | input | 8 | Value of the received byte |
| own_hit | input | 1 | Address byte matches the own address |
| ev_arlo | input | 1 | Arbitration lost |
| dec_vld | output | 1 | Decision valid |
| dec_ack | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| dec_pec | output | 1 | Decided byte was the check byte |
| alert_n | output | 1 | Alert line, active low |
| pec_err | output | 1 | Check byte mismatch seen this frame |
| pec_void | output | 1 | Check calculation spoiled by arbitration loss |

## Verification
A corrupted CRC accumulator stays hidden until the check byte arrives. At that point it shows as a not-acknowledge and a raised `pec_err` one clock after the strobe. A wrong captured ACK or PEC value under POS=1 appears one byte late, on the second data byte of a frame. A hardware clear that does not happen shows at once in `ctl_q` on the cycle after the start, stop or check byte. The reference model compares every output on every clock, so any divergence is reported within one cycle of the event that caused it.

// File: rtl/smbrx_pkg.sv
`timescale 1ns/1ps
package smbrx_pkg;
  localparam int DW     = 8;
  localparam int CTL_W  = 6;
  localparam int CB_ACK   = 0;
  localparam int CB_POS   = 1;
  localparam int CB_PEC   = 2;
  localparam int CB_ALERT = 3;
  localparam int CB_EN    = 4;
  localparam int CB_SRST  = 5;
  localparam logic [CTL_W-1:0] SRST_ONLY = CTL_W'(1) << CB_SRST;

  // one byte of MSB-first CRC update
  function automatic logic [DW-1:0] crc_step(input logic [DW-1:0] c,
                                             input logic [DW-1:0] d,
                                             input logic [DW-1:0] poly);
    logic [DW-1:0] r;
    r = c ^ d;
    for (int i = 0; i < DW; i++)
      r = r[DW-1] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/smbrx_ctlreg.sv
`timescale 1ns/1ps
module smbrx_ctlreg
  import smbrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             pec_clr,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = we ? wdata : q;
    if (nxt[CB_SRST]) nxt = SRST_ONLY;
    if (!nxt[CB_EN]) begin
      nxt[CB_ALERT] = 1'b0;
      nxt[CB_PEC]   = 1'b0;
      nxt[CB_POS]   = 1'b0;
      nxt[CB_ACK]   = 1'b0;
    end
    if (pec_clr) nxt[CB_PEC] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nxt;
endmodule

// File: rtl/smbrx_crc.sv
`timescale 1ns/1ps
module smbrx_crc
  import smbrx_pkg::*;
#(
  parameter logic [DW-1:0] POLY = 8'h07,
  parameter logic [DW-1:0] INIT = 8'h00
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclr,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           crc <= INIT;
    else if (sclr || clr) crc <= INIT;
    else if (upd)         crc <= crc_step(crc, din, POLY);
endmodule

// File: rtl/smbrx_seq.sv
`timescale 1ns/1ps
module smbrx_seq
  import smbrx_pkg::*;
#(
  parameter logic [DW-2:0] ARA = 7'b0001100
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclr,
  input  logic          smb_mode,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_byte,
  input  logic [DW-1:0] rx_data,
  input  logic          own_hit,
  input  logic          ev_arlo,
  input  logic          c_ack,
  input  logic          c_pos,
  input  logic          c_pec,
  input  logic          c_alert,
  input  logic [DW-1:0] crc_cur,
  output logic          crc_clr,
  output logic          crc_upd,
  output logic          pec_done,
  output logic          dec_vld,
  output logic          dec_ack,
  output logic          dec_pec,
  output logic          pec_err,
  output logic          pec_void
);
  logic want_addr, addressed, snap_ack, snap_pec;
  logic byte_ok, is_addr, is_data, ara_hit, addr_ack;
  logic use_ack, use_pec, pec_bad;

  always_comb begin
    byte_ok  = ev_byte & ~ev_start & ~sclr;
    is_addr  = byte_ok & want_addr;
    is_data  = byte_ok & ~want_addr & addressed;
    ara_hit  = smb_mode & (rx_data[DW-1:1] == ARA);
    addr_ack = ara_hit ? c_alert : own_hit;
    use_ack  = c_pos ? snap_ack : c_ack;
    use_pec  = c_pos ? snap_pec : c_pec;
    pec_done = is_data & use_pec;
    pec_bad  = pec_void | (rx_data != crc_cur);
    crc_clr  = ev_start;
    crc_upd  = is_addr | (is_data & ~use_pec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_addr <= 1'b0; addressed <= 1'b0; snap_ack <= 1'b0; snap_pec <= 1'b0;
      dec_vld <= 1'b0; dec_ack <= 1'b0; dec_pec <= 1'b0;
      pec_err <= 1'b0; pec_void <= 1'b0;
    end else if (sclr) begin
      want_addr <= 1'b0; addressed <= 1'b0; snap_ack <= 1'b0; snap_pec <= 1'b0;
      dec_vld <= 1'b0; dec_ack <= 1'b0; dec_pec <= 1'b0;
      pec_err <= 1'b0; pec_void <= 1'b0;
    end else begin
      dec_vld <= byte_ok;
      dec_pec <= pec_done;
      dec_ack <= is_addr ? addr_ack : (is_data & use_ack & ~(pec_done & pec_bad));
      if (byte_ok) begin
        snap_ack <= c_ack;
        snap_pec <= c_pec & ~pec_done;
      end
      if (pec_done & pec_bad) pec_err <= 1'b1;
      if (ev_arlo) pec_void <= 1'b1;
      if (ev_start) begin
        want_addr <= 1'b1; addressed <= 1'b0;
        pec_err <= 1'b0; pec_void <= 1'b0;
        snap_ack <= 1'b0; snap_pec <= 1'b0;
      end else if (ev_stop) begin
        want_addr <= 1'b0; addressed <= 1'b0;
      end else if (is_addr) begin
        want_addr <= 1'b0; addressed <= addr_ack;
      end
    end
  end
endmodule

// File: rtl/smbrx_ackpec.sv
`timescale 1ns/1ps
module smbrx_ackpec
  import smbrx_pkg::*;
#(
  parameter logic [DW-2:0] ARA_ADDR = 7'b0001100,
  parameter logic [DW-1:0] CRC_POLY = 8'h07,
  parameter logic [DW-1:0] CRC_INIT = 8'h00
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             smb_mode,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_byte,
  input  logic [DW-1:0]    rx_data,
  input  logic             own_hit,
  input  logic             ev_arlo,
  output logic             dec_vld,
  output logic             dec_ack,
  output logic             dec_pec,
  output logic             alert_n,
  output logic             pec_err,
  output logic             pec_void
);
  logic          sclr, pec_done, pec_clr, crc_clr, crc_upd;
  logic [DW-1:0] crc_cur;

  assign sclr    = ctl_q[CB_SRST] | ~ctl_q[CB_EN];
  assign pec_clr = ev_start | ev_stop | pec_done;
  assign alert_n = ~ctl_q[CB_ALERT];

  smbrx_ctlreg u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .pec_clr(pec_clr), .q(ctl_q)
  );

  smbrx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .clr(crc_clr), .upd(crc_upd),
    .din(rx_data), .crc(crc_cur)
  );

  smbrx_seq #(.ARA(ARA_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .smb_mode(smb_mode),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte),
    .rx_data(rx_data), .own_hit(own_hit), .ev_arlo(ev_arlo),
    .c_ack(ctl_q[CB_ACK]), .c_pos(ctl_q[CB_POS]), .c_pec(ctl_q[CB_PEC]),
    .c_alert(ctl_q[CB_ALERT]), .crc_cur(crc_cur),
    .crc_clr(crc_clr), .crc_upd(crc_upd), .pec_done(pec_done),
    .dec_vld(dec_vld), .dec_ack(dec_ack), .dec_pec(dec_pec),
    .pec_err(pec_err), .pec_void(pec_void)
  );
endmodule

// File: rtl/smbrx_ackpec_chk.sv
`timescale 1ns/1ps
module smbrx_ackpec_chk
  import smbrx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             ev_arlo,
  input logic [CTL_W-1:0] ctl_q,
  input logic             dec_vld,
  input logic             dec_ack,
  input logic             dec_pec,
  input logic             pec_err,
  input logic             pec_void
);
  // R2
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CB_SRST] |=> !dec_vld && !pec_err);

  // R3
  dis_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[CB_EN] |-> (ctl_q[CB_ALERT:CB_ACK] == '0));

  // R9
  start_pec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !ctl_q[CB_PEC]);

  // R9
  stop_pec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !ctl_q[CB_PEC]);

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pec_err) |-> dec_vld && dec_pec && !dec_ack);

  // R11
  pec_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pec |-> dec_vld);

  // R10
  start_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !pec_void && !pec_err);

  // R10
  arlo_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arlo && !ev_start && ctl_q[CB_EN] && !ctl_q[CB_SRST]) |=> pec_void);
endmodule

bind smbrx_ackpec smbrx_ackpec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_arlo(ev_arlo), .ctl_q(ctl_q), .dec_vld(dec_vld), .dec_ack(dec_ack),
  .dec_pec(dec_pec), .pec_err(pec_err), .pec_void(pec_void)
);

// File: tb/sim_smbrx_ackpec.sv
`timescale 1ns/1ps
module sim_smbrx_ackpec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0; logic [5:0] ctl_wdata = '0; logic [5:0] ctl_q;
  logic smb_mode = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
  logic [7:0] rx_data = '0; logic own_hit = 1'b0, ev_arlo = 1'b0;
  logic dec_vld, dec_ack, dec_pec, alert_n, pec_err, pec_void;
  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [7:0] e;

  localparam logic [5:0] K_ACK = 6'h01, K_POS = 6'h02, K_PEC = 6'h04,
                         K_ALR = 6'h08, K_EN = 6'h10, K_RST = 6'h20;

  always #5 clk = ~clk;

  smbrx_ackpec u0 (.*);

  // long-division form of the CRC-8 (0x107)
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [15:0] v;
    v = {c ^ d, 8'h00};
    for (int i = 15; i >= 8; i--)
      if (v[i]) v = v ^ (16'h0107 << (i - 8));
    return v[7:0];
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [5:0] m_ctl = '0; logic [7:0] m_crc = '0;
  bit m_want, m_in, m_sa, m_sp, m_err, m_void, m_dv, m_da, m_dp;
  always @(posedge clk) begin
    logic [5:0] nc; bit clr, b, ua, up, mm;
    if (!rst_n) begin
      m_ctl = '0; m_crc = '0; m_want = 0; m_in = 0; m_sa = 0; m_sp = 0;
      m_err = 0; m_void = 0; m_dv = 0; m_da = 0; m_dp = 0;
    end else begin
      clr = m_ctl[5] || !m_ctl[4];
      b = ev_byte && !ev_start;
      nc = ctl_we ? ctl_wdata : m_ctl;
      if (nc[5]) nc = K_RST;
      if (!nc[4]) nc[3:0] = 4'h0;
      if (clr) begin
        m_crc = '0; m_want = 0; m_in = 0; m_sa = 0; m_sp = 0;
        m_err = 0; m_void = 0; m_dv = 0; m_da = 0; m_dp = 0;
      end else begin
        m_dv = b; m_da = 0; m_dp = 0;
        ua = m_ctl[1] ? m_sa : m_ctl[0];
        up = m_ctl[1] ? m_sp : m_ctl[2];
        if (ev_start) begin
          m_want = 1; m_in = 0; m_err = 0; m_void = 0; m_crc = '0; m_sa = 0; m_sp = 0;
        end else begin
          if (b && m_want) begin
            m_da = (smb_mode && rx_data[7:1] == 7'b0001100) ? m_ctl[3] : own_hit;
            m_want = 0; m_in = m_da; m_crc = ref_crc(m_crc, rx_data);
            m_sa = m_ctl[0]; m_sp = m_ctl[2];
          end else if (b && m_in) begin
            if (up) begin
              mm = m_void || (rx_data != m_crc);
              m_dp = 1; m_da = ua && !mm;
              if (mm) m_err = 1;
              nc[2] = 1'b0;
            end else begin
              m_da = ua; m_crc = ref_crc(m_crc, rx_data);
            end
            m_sa = m_ctl[0]; m_sp = m_ctl[2] && !up;
          end else if (b) begin
            m_sa = m_ctl[0]; m_sp = m_ctl[2];
          end
          if (ev_arlo) m_void = 1;
          if (ev_stop) begin m_want = 0; m_in = 0; end
        end
      end
      if (ev_start || ev_stop) nc[2] = 1'b0;
      m_ctl = nc;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    cmp("R3 ctl_q model", ctl_q, m_ctl);
    cmp("R4 alert_n model", alert_n, !m_ctl[3]);
    cmp("R11 dec_vld model", dec_vld, m_dv);
    cmp("R11 dec_ack model", dec_ack, m_da);
    cmp("R6 dec_pec model", dec_pec, m_dp);
    cmp("R8 pec_err model", pec_err, m_err);
    cmp("R10 pec_void model", pec_void, m_void);
  end

  task automatic wr(input logic [5:0] v);
    @(negedge clk) ctl_we = 1; ctl_wdata = v;
    @(negedge clk) ctl_we = 0;
  endtask
  task automatic do_start(); @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0; endtask
  task automatic do_stop();  @(negedge clk) ev_stop = 1;  @(negedge clk) ev_stop = 0;  endtask
  task automatic do_arlo();  @(negedge clk) ev_arlo = 1;  @(negedge clk) ev_arlo = 0;  endtask
  task automatic send(input logic [7:0] d, input logic hit);
    @(negedge clk) ev_byte = 1; rx_data = d; own_hit = hit;
    @(negedge clk) ev_byte = 0; own_hit = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1 ctl_q", ctl_q, 0); cmp("R1 alert_n", alert_n, 1);
    cmp("R1 dec_vld", dec_vld, 0); cmp("R1 pec_err", pec_err + pec_void, 0);
    rst_n = 1;
    @(negedge clk);
    // R3 disabled clears the other bits
    wr(K_ALR | K_ACK | K_POS | K_PEC); cmp("R3 bits while off", ctl_q, 0);
    do_start(); send(8'hA0, 1); cmp("R3 no decision off", dec_vld, 0);
    // R4 alert line
    wr(K_EN | K_ALR); cmp("R4 alert low", alert_n, 0);
    wr(K_EN);         cmp("R4 alert high", alert_n, 1);
    // R5 alert response address
    smb_mode = 1;
    wr(K_EN | K_ALR | K_ACK); do_start(); send(8'h19, 0);
    cmp("R5 ARA acked", {dec_vld, dec_ack}, 2'b11);
    wr(K_EN | K_ACK); do_start(); send(8'h19, 0);
    cmp("R5 ARA nacked", {dec_vld, dec_ack}, 2'b10);
    do_start(); send(8'hA6, 0); cmp("R5 miss nacked", dec_ack, 0);
    send(8'h11, 0); cmp("R5 frame ignored", dec_ack, 0);
    do_start(); send(8'hA0, 1); cmp("R5 own hit", dec_ack, 1);
    // R6 POS=0 two bytes
    send(8'h11, 0); cmp("R6 byte1 ack", dec_ack, 1);
    wr(K_EN); send(8'h22, 0); cmp("R6 byte2 nack", dec_ack, 0);
    do_stop();
    // R7 POS=1 two bytes
    wr(K_EN | K_POS | K_ACK); do_start(); send(8'hA0, 1);
    wr(K_EN | K_POS);
    send(8'h33, 0); cmp("R7 byte1 ack", dec_ack, 1);
    send(8'h44, 0); cmp("R7 byte2 nack", dec_ack, 0);
    do_stop();
    // R8 good check byte, POS=0
    wr(K_EN | K_ACK); do_start(); send(8'hA0, 1); send(8'h55, 0);
    e = ref_crc(ref_crc(8'h00, 8'hA0), 8'h55);
    wr(K_EN | K_ACK | K_PEC); send(e, 0);
    cmp("R8 good pec", {dec_vld, dec_ack, dec_pec, pec_err}, 4'b1110);
    cmp("R9 pec cleared after byte", ctl_q, K_EN | K_ACK);
    // R8 corrupted check byte
    do_start(); send(8'hA0, 1); send(8'h55, 0);
    wr(K_EN | K_ACK | K_PEC); send(e ^ 8'h01, 0);
    cmp("R8 bad pec", {dec_vld, dec_ack, dec_pec, pec_err}, 4'b1011);
    // R7 check byte under POS=1
    wr(K_EN | K_POS | K_ACK); do_start(); send(8'hA0, 1);
    wr(K_EN | K_POS | K_ACK | K_PEC);
    send(8'h5A, 0); cmp("R7 first not pec", {dec_ack, dec_pec}, 2'b10);
    send(ref_crc(ref_crc(8'h00, 8'hA0), 8'h5A), 0);
    cmp("R7 second is pec", {dec_ack, dec_pec, pec_err}, 3'b110);
    cmp("R9 pec cleared pos", ctl_q, K_EN | K_POS | K_ACK);
    // R9 start and stop clear the request
    wr(K_EN | K_PEC); do_start(); cmp("R9 start clears", ctl_q, K_EN);
    wr(K_EN | K_PEC); do_stop();  cmp("R9 stop clears", ctl_q, K_EN);
    // R10 arbitration loss spoils the check
    wr(K_EN | K_ACK); do_start(); send(8'hA0, 1); send(8'h77, 0);
    do_arlo(); cmp("R10 void set", pec_void, 1);
    wr(K_EN | K_ACK | K_PEC);
    send(ref_crc(ref_crc(8'h00, 8'hA0), 8'h77), 0);
    cmp("R10 forced mismatch", {dec_ack, dec_pec, pec_err}, 3'b011);
    do_start(); cmp("R10 start clears", {pec_void, pec_err}, 2'b00);
    // R2 soft reset
    wr(K_RST | K_EN | K_ACK); cmp("R2 held", ctl_q, K_RST);
    wr(K_RST | K_ALR);        cmp("R2 write ignored", ctl_q, K_RST);
    do_start(); send(8'hA0, 1); cmp("R2 no decision", dec_vld, 0);
    wr(K_EN | K_ACK); cmp("R2 released", ctl_q, K_EN | K_ACK);
    do_start(); send(8'hA0, 1); cmp("R2 works again", {dec_vld, dec_ack}, 2'b11);
    // R11 strobe lasts one cycle
    @(negedge clk); cmp("R11 single pulse", dec_vld, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule